// File: doc/BRIEF.md
# Open-LED and Over-Temperature Fault Qualifier

This block sits beside a bank of constant-current LED sink channels. It turns raw fault indications into error flags that can be trusted. Each channel has an analog comparator that reports when the channel's output voltage is below the open-LED threshold. That report means something only once the channel has been switched on long enough for its output to settle. The block therefore keeps a per-channel qualification timer and raises a channel's open-LED flag only after that timer has expired. The timer of each higher-numbered channel is longer by a fixed stagger, because the channels turn on one after another.

An over-temperature input is synchronized and passed through as the thermal flag. Both kinds of fault drive a shared active-low error line, modelled as an output enable plus a data value fixed at zero, so that several blocks can be wire-ORed. The blank input removes open-LED faults from the error line but never hides the thermal fault. A falling edge on the latch input captures all qualified flags into a 17-bit status word that the serial readback path can shift out.

The comparator and thermal inputs are treated as asynchronous and each passes through a two-flop synchronizer. The channel-on enables, blank and latch come from logic on the same clock.

Top module: `led_fault_qualifier`

## Requirements
- R1: A channel's open-LED flag (`lod_flag[i]`) is 1 only while its `chan_on[i]` is 1, its qualification time has elapsed, and its synchronized comparator bit is 1. Otherwise it is 0.
- R2: With the comparator bit already settled high, channel 0's flag rises on the QUAL_CYCLES-th rising clock edge at which `chan_on[0]` is sampled high without a break, and not one edge earlier.
- R3: Channel i's qualification time is QUAL_CYCLES + i*STAGGER_CYCLES consecutive on-cycles. With the defaults, channel 1 needs 129 and channel 15 needs 185.
- R4: A channel's qualification timer restarts from zero whenever its enable is sampled low. After it turns back on, the full qualification time must elapse again.
- R5: `err_oe` is 1 (line pulled low) when any open-LED flag is 1 while blank is 0, or when the thermal flag is 1. Otherwise it is 0. `err_data` is always 0.
- R6: While `blank` is 1, open-LED faults do not set `err_oe`, the `lod_flag` outputs themselves are unchanged, and the thermal flag still sets `err_oe`.
- R7: `tef_flag` equals `therm_hot` as sampled two rising edges earlier. It clears once the input returns low.
- R8: A change on a `cmp_low` bit reaches the matching open-LED flag on the second rising edge after the change.
- R9: At the rising edge where `latch` is sampled 0 after being sampled 1 at the previous edge, `status_snap` loads the current flags: bits [15:0] take `lod_flag[15:0]` and bit 16 takes `tef_flag`. At every other edge it holds, including while `latch` stays 1.
- R10: While `rst_n` is 0, all flags, `err_oe`, `status_snap` and all timers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for timers, synchronizers and snapshot |
| rst_n | input | 1 | Synchronous active-low reset |
| chan_on | input | 16 | Per-channel sink enable, synchronous |
| cmp_low | input | 16 | Per-channel comparator: output below open-LED threshold, asynchronous |
| therm_hot | input | 1 | Over-temperature indication, asynchronous |
| blank | input | 1 | Masks open-LED faults from the error line |
| latch | input | 1 | Status capture strobe; captures on its falling edge |
| lod_flag | output | 16 | Qualified open-LED flags |
| tef_flag | output | 1 | Synchronized thermal flag |
| err_oe | output | 1 | Error line drive enable (1 = pull line low) |
| err_data | output | 1 | Error line drive value, constant 0 |
| status_snap | output | 17 | Captured status: [15:0] open-LED, [16] thermal |

## Verification
On every cycle the assertions check the following. The error enable follows the thermal flag. Blank suppresses open-LED faults from the error line. No channel reports a fault while it is off. The thermal flag tracks its input with exactly two edges of latency. The snapshot loads only on a latch fall and holds at every other edge. The exact qualification edge of each channel, its stagger and the timer restart after turn-off depend on long runs of on-cycles, so only the bench's scenarios show them: it counts cycles to the predicted threshold and checks one edge before and at the threshold.

// File: rtl/lfq_pkg.sv
// Package: shared helpers for the fault qualifier.
// Assumes: qualification and stagger counts are non-negative.
package lfq_pkg;

    // Qualification threshold of a given channel, in on-cycles.
    function automatic int chan_limit(input int qual, input int stagger, input int idx);
        return qual + idx * stagger;
    endfunction

endpackage

// File: rtl/lfq_sync.sv
// Module: two-flop synchronizer for a vector of asynchronous bits.
// Assumes: bits are independent; no coherence across the vector is needed.
module lfq_sync #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] meta_q;

    // Two register stages, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q   <= '0;
            sync_out <= '0;
        end else begin
            meta_q   <= async_in;
            sync_out <= meta_q;
        end
    end
endmodule

// File: rtl/lfq_chan_timer.sv
// Module: per-channel qualification timer.
// Counts consecutive cycles with the channel on, saturates at LIMIT and
// restarts whenever the channel is sampled off.
// Assumes: LIMIT >= 1 and fits in CW bits.
module lfq_chan_timer #(
    parameter int LIMIT = 125,
    parameter int CW    = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic on_i,
    output logic qualified
);
    logic [CW-1:0] cnt_q;

    // Saturating on-time counter; clears when the channel is off.
    always_ff @(posedge clk) begin
        if (!rst_n || !on_i) begin
            cnt_q <= '0;
        end else if (cnt_q != CW'(LIMIT)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // The window has elapsed once the counter reaches its limit.
    always_comb qualified = (cnt_q == CW'(LIMIT));
endmodule

// File: rtl/led_fault_qualifier.sv
// Module: qualifies per-channel open-LED comparator bits and a thermal input
// into error flags, drives an open-drain style error line and captures a
// status snapshot on the falling edge of the latch strobe.
// Assumes: chan_on, blank and latch are synchronous to clk; cmp_low and
// therm_hot are asynchronous. QUAL_CYCLES >= 1.
module led_fault_qualifier #(
    parameter int NUM_CH         = 16,
    parameter int QUAL_CYCLES    = 125,
    parameter int STAGGER_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] chan_on,
    input  logic [NUM_CH-1:0] cmp_low,
    input  logic              therm_hot,
    input  logic              blank,
    input  logic              latch,
    output logic [NUM_CH-1:0] lod_flag,
    output logic              tef_flag,
    output logic              err_oe,
    output logic              err_data,
    output logic [NUM_CH:0]   status_snap
);
    localparam int MAX_LIMIT = lfq_pkg::chan_limit(QUAL_CYCLES, STAGGER_CYCLES, NUM_CH - 1);
    localparam int CW        = $clog2(MAX_LIMIT + 1);

    logic [NUM_CH-1:0] cmp_s;
    logic [NUM_CH-1:0] qual;
    logic              therm_s;
    logic              latch_d;

    lfq_sync #(.WIDTH(NUM_CH)) u_cmp_sync (
        .clk(clk), .rst_n(rst_n), .async_in(cmp_low), .sync_out(cmp_s)
    );

    lfq_sync #(.WIDTH(1)) u_therm_sync (
        .clk(clk), .rst_n(rst_n), .async_in(therm_hot), .sync_out(therm_s)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        lfq_chan_timer #(
            .LIMIT(lfq_pkg::chan_limit(QUAL_CYCLES, STAGGER_CYCLES, i)),
            .CW   (CW)
        ) u_timer (
            .clk(clk), .rst_n(rst_n), .on_i(chan_on[i]), .qualified(qual[i])
        );
    end

    // Qualified fault flags: on, window elapsed, comparator low.
    always_comb lod_flag = chan_on & qual & cmp_s;

    // Thermal flag follows the synchronized sensor.
    always_comb tef_flag = therm_s;

    // Error line: unmasked open-LED faults or thermal; drive value fixed low.
    always_comb begin
        err_oe   = ((|lod_flag) && !blank) || tef_flag;
        err_data = 1'b0;
    end

    // Latch history and snapshot capture on the falling edge of latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_d     <= 1'b0;
            status_snap <= '0;
        end else begin
            latch_d <= latch;
            if (latch_d && !latch) begin
                status_snap <= {tef_flag, lod_flag};
            end
        end
    end
endmodule

// File: rtl/lfq_checker.sv
// Module: property checker for led_fault_qualifier, attached by bind.
// Assumes: same parameters as the bound instance.
module lfq_checker #(
    parameter int NUM_CH = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] chan_on,
    input logic              therm_hot,
    input logic              blank,
    input logic              latch,
    input logic [NUM_CH-1:0] lod_flag,
    input logic              tef_flag,
    input logic              err_oe,
    input logic              err_data,
    input logic [NUM_CH:0]   status_snap
);
    logic [1:0] since_rst;

    // Counts edges since reset (saturating) so history checks start clean.
    always_ff @(posedge clk) begin
        if (!rst_n) since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 1'b1;
    end

    a_r1_off_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (lod_flag & ~chan_on) == '0);

    a_r5_therm_drives_err: assert property (@(posedge clk) disable iff (!rst_n)
        tef_flag |-> (err_oe && !err_data));

    a_r6_blank_masks_lod: assert property (@(posedge clk) disable iff (!rst_n)
        (blank && !tef_flag) |-> !err_oe);

    a_r7_therm_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3) |-> (tef_flag == $past(therm_hot, 2)));

    a_r9_snap_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst != 2'd0 && $past(latch) && !latch) |=>
            (status_snap == $past({tef_flag, lod_flag})));

    a_r9_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst != 2'd0 && !($past(latch) && !latch)) |=> $stable(status_snap));
endmodule

bind led_fault_qualifier lfq_checker #(.NUM_CH(NUM_CH)) u_chk (
    .clk(clk), .rst_n(rst_n), .chan_on(chan_on), .therm_hot(therm_hot),
    .blank(blank), .latch(latch), .lod_flag(lod_flag), .tef_flag(tef_flag),
    .err_oe(err_oe), .err_data(err_data), .status_snap(status_snap)
);

// File: tb/sim_led_fault_qualifier.sv
module sim_led_fault_qualifier;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] chan_on = '0;
    logic [15:0] cmp_low = '0;
    logic        therm_hot = 1'b0;
    logic        blank = 1'b0;
    logic        latch = 1'b0;
    logic [15:0] lod_flag;
    logic        tef_flag;
    logic        err_oe;
    logic        err_data;
    logic [16:0] status_snap;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    led_fault_qualifier u0 (
        .clk(clk), .rst_n(rst_n), .chan_on(chan_on), .cmp_low(cmp_low),
        .therm_hot(therm_hot), .blank(blank), .latch(latch),
        .lod_flag(lod_flag), .tef_flag(tef_flag), .err_oe(err_oe),
        .err_data(err_data), .status_snap(status_snap)
    );

    // Vector: {on, cmp, therm, blank, edges, exp_lod, exp_tef, exp_oe}
    // Defaults: QUAL_CYCLES=125, STAGGER_CYCLES=4.
    localparam int NV = 16;
    localparam logic [60:0] VEC [NV] = '{
        {16'h0000, 16'hFFFF, 1'b0, 1'b0, 9'd4,   16'h0000, 1'b0, 1'b0}, // R1 off
        {16'h0001, 16'hFFFF, 1'b0, 1'b0, 9'd124, 16'h0000, 1'b0, 1'b0}, // R2 one early
        {16'h0001, 16'hFFFF, 1'b0, 1'b0, 9'd1,   16'h0001, 1'b0, 1'b1}, // R2 at limit
        {16'h0001, 16'hFFFF, 1'b0, 1'b1, 9'd1,   16'h0001, 1'b0, 1'b0}, // R6 masked
        {16'h0001, 16'hFFFF, 1'b1, 1'b1, 9'd2,   16'h0001, 1'b1, 1'b1}, // R6 thermal
        {16'h0001, 16'hFFFF, 1'b0, 1'b0, 9'd2,   16'h0001, 1'b0, 1'b1}, // R7 clear
        {16'h0000, 16'hFFFF, 1'b0, 1'b0, 9'd1,   16'h0000, 1'b0, 1'b0}, // R4 off
        {16'h0001, 16'hFFFF, 1'b0, 1'b0, 9'd124, 16'h0000, 1'b0, 1'b0}, // R4 restart
        {16'h8001, 16'hFFFF, 1'b0, 1'b0, 9'd1,   16'h0001, 1'b0, 1'b1}, // R2 again
        {16'h8001, 16'hFFFF, 1'b0, 1'b0, 9'd183, 16'h0001, 1'b0, 1'b1}, // R3 ch15 early
        {16'h8001, 16'hFFFF, 1'b0, 1'b0, 9'd1,   16'h8001, 1'b0, 1'b1}, // R3 ch15 185
        {16'h0000, 16'hFFFF, 1'b0, 1'b0, 9'd2,   16'h0000, 1'b0, 1'b0}, // R4 clear
        {16'h0003, 16'hFFFF, 1'b0, 1'b0, 9'd125, 16'h0001, 1'b0, 1'b1}, // R3 ch0 only
        {16'h0003, 16'hFFFF, 1'b0, 1'b0, 9'd3,   16'h0001, 1'b0, 1'b1}, // R3 ch1 early
        {16'h0003, 16'hFFFF, 1'b0, 1'b0, 9'd1,   16'h0003, 1'b0, 1'b1}, // R3 ch1 129
        {16'h0003, 16'h0001, 1'b0, 1'b0, 9'd2,   16'h0001, 1'b0, 1'b1}  // R8 cmp
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        tick(3);
        // R10: reset state
        check("R10 lod", 32'(lod_flag), 32'h0);
        check("R10 oe", 32'(err_oe), 32'h0);
        check("R10 snap", 32'(status_snap), 32'h0);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            chan_on   = VEC[v][60:45];
            cmp_low   = VEC[v][44:29];
            therm_hot = VEC[v][28];
            blank     = VEC[v][27];
            tick(int'(VEC[v][26:18]));
            check($sformatf("R1/R2/R3/R4/R8 lod v%0d", v), 32'(lod_flag), 32'(VEC[v][17:2]));
            check($sformatf("R7 tef v%0d", v), 32'(tef_flag), 32'(VEC[v][1]));
            check($sformatf("R5/R6 oe v%0d", v), 32'(err_oe), 32'(VEC[v][0]));
            check($sformatf("R5 data v%0d", v), 32'(err_data), 32'h0);
        end

        // R9: no capture while latch is held high
        latch = 1'b1;
        tick(1);
        check("R9 no capture while high", 32'(status_snap), 32'h0);
        latch = 1'b0;
        tick(1);
        check("R9 capture on fall", 32'(status_snap), 32'h00001);
        chan_on = '0;
        tick(1);
        check("R1 off clears flag", 32'(lod_flag), 32'h0);
        check("R9 hold after change", 32'(status_snap), 32'h00001);

        // R9: thermal bit lands in bit 16
        therm_hot = 1'b1;
        tick(2);
        check("R7 tef set", 32'(tef_flag), 32'h1);
        latch = 1'b1;
        tick(1);
        latch = 1'b0;
        tick(1);
        check("R9 thermal snapshot", 32'(status_snap), 32'h10000);
        therm_hot = 1'b0;
        tick(1);
        check("R7 one edge late still set", 32'(tef_flag), 32'h1);
        tick(1);
        check("R7 tef cleared", 32'(tef_flag), 32'h0);
        check("R5 oe released", 32'(err_oe), 32'h0);

        // R10: reset mid-run clears snapshot
        rst_n = 1'b0;
        tick(1);
        check("R10 snap cleared", 32'(status_snap), 32'h0);
        rst_n = 1'b1;

        done = 1'b1;
        summary();
    end
endmodule